// File: doc/BRIEF.md
# Command/Response Byte FIFO Status Engine

This block is the device side of a byte-wide command/response mailbox for a security module. A host writes a command one byte at a time into a data FIFO register, reads a status register to see whether more bytes are wanted, sets a go bit to start execution, and then drains the response through the same FIFO register. A 16-bit burst count tells the host how many bytes it can move before it has to check again.

The engine decides when a command is complete on its own. Every command begins with a 10-byte header, and header bytes 2 to 5 carry the total length as a big-endian number. The data-expect flag follows that length. Execution is modelled as a loopback. After a fixed delay set by a parameter, the accepted command bytes come back in order as the response. Writing the command-ready bit abandons whatever is in progress and empties the engine.

Top module: `cmdrsp_engine`

## Requirements
- R1: After reset the flag byte reads 0xC8 (bit 7 valid, bit 6 command-ready, bit 3 expect) and the burst count equals DEPTH.
- R2: Register byte offsets are: flags at 0x018, burst count low byte at 0x019, burst count high byte at 0x01A, and data FIFO at 0x024. In the flag byte, bit 7 always reads 1, bit 5 (go) always reads 0, and bits 1 and 0 read 0. Reads of any other offset return 0x00. Read data appears on the cycle after the read strobe.
- R3: A write to 0x024 stores one byte. The first stored byte clears command-ready.
- R4: Expect (bit 3) stays 1 until the stored byte count reaches the larger of 10 and the length in header bytes 2..5, where byte 2 is the most significant.
- R5: A FIFO write is dropped and sets overflow (flag bit 4 is avail, bit 2 is overflow) in any of these cases: expect is 0, the buffer holds DEPTH bytes, or the engine is executing or responding. A dropped write does not change the burst count.
- R6: A flag-byte write with bit 5 set is ignored while expect is 1.
- R7: A go write accepted with expect 0 starts execution. During execution avail is 0 and the burst count is 0. Avail rises EXEC_DELAY+1 cycles after the go write.
- R8: The response is the accepted command bytes in the order they were written, and its length is the number of accepted bytes.
- R9: During command entry the burst count is DEPTH minus the stored bytes. During response it is the number of bytes not yet read. Avail reads 0 once the last byte has been read, and later FIFO reads return 0x00.
- R10: A flag-byte write with bit 6 set aborts from any state. The engine returns to the R1 status and burst count, and overflow is cleared.
- R11: A single flag-byte write with both bit 6 and bit 5 set performs the abort only. No execution starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |

## Verification
Two functions can land on the same register write: go and abort. A host can set bit 5 and bit 6 of the flag byte in one write. The bench issues exactly that write on a complete command with expect already clear, so go alone would be accepted. It then judges the outcome by reading the flag byte straight away and again twenty cycles later. Both reads must show the idle value 0xC8 and no avail. The same judgement applies to an abort issued while execution is running, where the loopback response must never appear.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam logic [11:0] OFF_FLAGS = 12'h018;
  localparam logic [11:0] OFF_BC_LO = 12'h019;
  localparam logic [11:0] OFF_BC_HI = 12'h01A;
  localparam logic [11:0] OFF_DATA  = 12'h024;

  localparam int HDR_BYTES = 10;
  localparam int LEN_FIRST = 2;
  localparam int LEN_LAST  = 5;
  localparam int BC_W      = 16;

  localparam int F_VALID = 7;
  localparam int F_READY = 6;
  localparam int F_GO    = 5;
  localparam int F_AVAIL = 4;
  localparam int F_EXP   = 3;
  localparam int F_OVF   = 2;

  typedef enum logic [1:0] {
    ST_ENTRY = 2'd0,
    ST_EXEC  = 2'd1,
    ST_RESP  = 2'd2
  } cre_state_e;
endpackage

// File: rtl/cre_len_track.sv
module cre_len_track #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_req,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] cnt,
  output logic          expect_more,
  output logic          accept
);
  import cre_pkg::*;

  logic [31:0] len_q;
  logic [31:0] cnt_ext;

  assign cnt_ext     = {{(32-CW){1'b0}}, cnt};
  assign expect_more = (cnt_ext < 32'(HDR_BYTES)) || (cnt_ext < len_q);
  assign accept      = wr_req && expect_more && (cnt_ext < 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      len_q <= '0;
    end else if (accept) begin
      cnt <= cnt + 1'b1;
      if (cnt_ext >= 32'(LEN_FIRST) && cnt_ext <= 32'(LEN_LAST))
        len_q <= {len_q[23:0], wdata};
    end
  end
endmodule

// File: rtl/cre_buffer.sv
module cre_buffer #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cre_ctrl.sv
module cre_ctrl #(
  parameter int DEPTH      = 64,
  parameter int EXEC_DELAY = 8,
  parameter int CW         = $clog2(DEPTH + 1),
  parameter int TW         = $clog2(EXEC_DELAY + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flags_wr,
  input  logic [7:0]          wdata,
  input  logic                fifo_wr,
  input  logic                fifo_rd,
  input  logic                expect_more,
  input  logic                accept,
  input  logic [CW-1:0]       cnt,
  output cre_pkg::cre_state_e st,
  output logic                abort,
  output logic                ovf,
  output logic [CW-1:0]       rd_cnt,
  output logic                rd_ok
);
  import cre_pkg::*;

  logic [TW-1:0] timer;
  logic          go;

  assign abort = flags_wr && wdata[F_READY];
  assign go    = flags_wr && wdata[F_GO] && !wdata[F_READY] &&
                 (st == ST_ENTRY) && !expect_more;
  assign rd_ok = (st == ST_RESP) && (rd_cnt < cnt);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st     <= ST_ENTRY;
      timer  <= '0;
      ovf    <= 1'b0;
      rd_cnt <= '0;
    end else begin
      if (fifo_wr && !accept) ovf <= 1'b1;
      case (st)
        ST_ENTRY: if (go) begin
          st    <= ST_EXEC;
          timer <= TW'(EXEC_DELAY);
        end
        ST_EXEC: begin
          if (timer == '0) st <= ST_RESP;
          else             timer <= timer - 1'b1;
        end
        ST_RESP: if (fifo_rd && rd_ok) rd_cnt <= rd_cnt + 1'b1;
        default: st <= ST_ENTRY;
      endcase
    end
  end
endmodule

// File: rtl/cmdrsp_engine.sv
module cmdrsp_engine #(
  parameter int DEPTH      = 64,
  parameter int EXEC_DELAY = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata
);
  import cre_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  cre_state_e       st;
  logic [CW-1:0]    cnt, rd_cnt;
  logic             expect_more, accept, abort, ovf, rd_ok, avail;
  logic             flags_wr, fifo_wr, fifo_rd;
  logic [BC_W-1:0]  burst;
  logic [7:0]       flags, reg_q, buf_q;
  logic             sel_data_q, data_ok_q;

  assign flags_wr = wr_en && (addr == OFF_FLAGS);
  assign fifo_wr  = wr_en && (addr == OFF_DATA);
  assign fifo_rd  = rd_en && (addr == OFF_DATA);

  cre_len_track #(.DEPTH(DEPTH), .CW(CW)) u_len (
    .clk(clk), .rst(rst), .clr(abort),
    .wr_req(fifo_wr && (st == ST_ENTRY)), .wdata(wdata),
    .cnt(cnt), .expect_more(expect_more), .accept(accept)
  );

  cre_ctrl #(.DEPTH(DEPTH), .EXEC_DELAY(EXEC_DELAY), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .flags_wr(flags_wr), .wdata(wdata),
    .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .expect_more(expect_more),
    .accept(accept), .cnt(cnt), .st(st), .abort(abort), .ovf(ovf),
    .rd_cnt(rd_cnt), .rd_ok(rd_ok)
  );

  cre_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(accept), .waddr(cnt[AW-1:0]), .wdata(wdata),
    .re(fifo_rd), .raddr(rd_cnt[AW-1:0]), .rdata(buf_q)
  );

  assign avail = rd_ok;

  always_comb begin
    case (st)
      ST_ENTRY: burst = BC_W'(DEPTH) - BC_W'(cnt);
      ST_RESP:  burst = BC_W'(cnt) - BC_W'(rd_cnt);
      default:  burst = '0;
    endcase
    flags          = '0;
    flags[F_VALID] = 1'b1;
    flags[F_READY] = (st == ST_ENTRY) && (cnt == '0);
    flags[F_AVAIL] = avail;
    flags[F_EXP]   = (st == ST_ENTRY) && expect_more;
    flags[F_OVF]   = ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      sel_data_q <= 1'b0;
      data_ok_q  <= 1'b0;
    end else if (rd_en) begin
      sel_data_q <= fifo_rd;
      data_ok_q  <= rd_ok;
      case (addr)
        OFF_FLAGS: reg_q <= flags;
        OFF_BC_LO: reg_q <= burst[7:0];
        OFF_BC_HI: reg_q <= burst[15:8];
        default:   reg_q <= 8'h00;
      endcase
    end
  end

  assign rdata = sel_data_q ? (data_ok_q ? buf_q : 8'h00) : reg_q;
endmodule

// File: rtl/cre_chk.sv
module cre_chk #(
  parameter int CW = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [11:0]         addr,
  input logic [7:0]          wdata,
  input cre_pkg::cre_state_e st,
  input logic [CW-1:0]       cnt,
  input logic                expect_more,
  input logic                ovf,
  input logic                avail,
  input logic [15:0]         burst
);
  import cre_pkg::*;

  AST_EXPECT_HDR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTRY && !expect_more) |-> (cnt >= CW'(HDR_BYTES))); // R4

  AST_OVF_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_DATA && st != ST_ENTRY) |=> ovf); // R5

  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_FLAGS && wdata[F_GO] && expect_more) |=> (st == ST_ENTRY)); // R6

  AST_EXEC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC) |-> (burst == 16'd0 && !avail)); // R7

  AST_AVAIL_RESP: assert property (@(posedge clk) disable iff (rst)
    avail |-> (st == ST_RESP)); // R7

  AST_BURST_DEC: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFF_DATA && avail && !(wr_en && addr == OFF_FLAGS))
      |=> (burst == $past(burst) - 16'd1)); // R9

  AST_ABORT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_FLAGS && wdata[F_READY])
      |=> (st == ST_ENTRY && cnt == '0 && !ovf)); // R10
endmodule

bind cmdrsp_engine cre_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .st(st), .cnt(cnt), .expect_more(expect_more),
  .ovf(ovf), .avail(avail), .burst(burst)
);

// File: tb/cmdrsp_engine_bench.sv
module cmdrsp_engine_bench;
  localparam int DEPTH = 64;
  localparam int EXEC_DELAY = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] cmd [16];

  always #5 clk = ~clk;

  cmdrsp_engine #(.DEPTH(DEPTH), .EXEC_DELAY(EXEC_DELAY)) u_cmdrsp_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic expect_sts(input string tag, input int exp_flags, input int exp_bc);
    logic [7:0] f, lo, hi;
    rd(12'h018, f);
    rd(12'h019, lo);
    rd(12'h01A, hi);
    chk({tag, " flags"}, f, exp_flags);
    chk({tag, " burst"}, {hi, lo}, exp_bc);
  endtask

  task automatic build(input int len);
    cmd[0] = 8'h80; cmd[1] = 8'h01;
    cmd[2] = 8'h00; cmd[3] = 8'h00; cmd[4] = 8'h00; cmd[5] = 8'(len);
    for (int i = 6; i < 16; i++) cmd[i] = 8'(8'hA0 + i);
  endtask

  task automatic wait_avail(input string tag);
    logic [7:0] f;
    int n = 0;
    f = 8'h00;
    while (!f[4] && n < 60) begin
      rd(12'h018, f);
      n++;
    end
    chk({tag, " avail seen"}, f[4], 1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    expect_sts("R1 reset", 8'hC8, DEPTH);
    rd(12'h030, d);
    chk("R2 unmapped offset", d, 8'h00);
  endtask

  task automatic t_full_cycle();
    logic [7:0] d;
    build(12);
    wr(12'h024, cmd[0]);
    expect_sts("R3 first byte", 8'h88, DEPTH - 1);
    for (int i = 1; i < 6; i++) wr(12'h024, cmd[i]);
    expect_sts("R9 entry burst", 8'h88, DEPTH - 6);
    for (int i = 6; i < 11; i++) wr(12'h024, cmd[i]);
    wr(12'h018, 8'h20);
    expect_sts("R6 early go ignored", 8'h88, DEPTH - 11);
    wr(12'h024, cmd[11]);
    expect_sts("R4 last byte", 8'h80, DEPTH - 12);
    wr(12'h024, 8'h55);
    expect_sts("R5 excess dropped", 8'h84, DEPTH - 12);
    wr(12'h018, 8'h20);
    expect_sts("R7 executing", 8'h84, 0);
    wait_avail("R7");
    expect_sts("R9 response burst", 8'h94, 12);
    for (int i = 0; i < 12; i++) begin
      rd(12'h024, d);
      chk($sformatf("R8 byte %0d", i), d, cmd[i]);
      if (i == 4) expect_sts("R9 partial", 8'h94, 7);
    end
    expect_sts("R9 drained", 8'h84, 0);
    rd(12'h024, d);
    chk("R9 read past end", d, 8'h00);
    wr(12'h024, 8'h77);
    expect_sts("R5 write during response", 8'h84, 0);
    wr(12'h018, 8'h40);
    expect_sts("R10 abort after response", 8'hC8, DEPTH);
  endtask

  task automatic t_short_len();
    logic [7:0] d;
    build(4);
    for (int i = 0; i < 9; i++) wr(12'h024, cmd[i]);
    expect_sts("R4 header floor", 8'h88, DEPTH - 9);
    wr(12'h024, cmd[9]);
    expect_sts("R4 header complete", 8'h80, DEPTH - 10);
    wr(12'h018, 8'h20);
    wait_avail("R8 short");
    expect_sts("R8 short length", 8'h90, 10);
    rd(12'h024, d);
    chk("R8 short first byte", d, cmd[0]);
    wr(12'h018, 8'h40);
    expect_sts("R10 abort mid response", 8'hC8, DEPTH);
  endtask

  task automatic t_abort_entry_exec();
    build(10);
    for (int i = 0; i < 3; i++) wr(12'h024, cmd[i]);
    wr(12'h018, 8'h40);
    expect_sts("R10 abort in entry", 8'hC8, DEPTH);
    for (int i = 0; i < 10; i++) wr(12'h024, cmd[i]);
    wr(12'h018, 8'h20);
    wr(12'h018, 8'h40);
    expect_sts("R10 abort in exec", 8'hC8, DEPTH);
    repeat (20) @(negedge clk);
    expect_sts("R10 no late response", 8'hC8, DEPTH);
  endtask

  task automatic t_go_and_ready();
    build(10);
    for (int i = 0; i < 10; i++) wr(12'h024, cmd[i]);
    wr(12'h018, 8'h60);
    expect_sts("R11 same write", 8'hC8, DEPTH);
    repeat (20) @(negedge clk);
    expect_sts("R11 still idle", 8'hC8, DEPTH);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_cycle();
    t_short_len();
    t_abort_entry_exec();
    t_go_and_ready();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule